// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the serial core of an SPI controller. A parent block hands it parallel words through a one-word holding stage. The block shifts each word out on the serial data-out pin, most significant bit first, and assembles the bits arriving on the data-in pin into a receive word. When a word completes, it raises a single-cycle done strobe with the received word. Word length, clock polarity, clock phase and the master clock divider come from static control inputs, which must not change while a word is in flight.

In master mode the block generates the serial clock from the module clock, and samples data-in directly. In slave mode it follows an external serial clock through a synchronizer, and can be gated by an active-low select pin. A control input decides whether that pin gates the slave or is ignored. When the serial clock is idle it rests at the polarity level. When the block is idle, or when forcing is requested, the data-out pin carries a programmed level. A synchronized copy of the data-in pin is also provided.

Top module: `spi_shift_core`

## Requirements
- R1: `word_sel_i` selects the word length N: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 9 in master mode. A master word produces exactly 2N serial clock transitions. `rx_data_o` holds the N received bits right-justified, with the upper bits zero.
- R2: In 9-bit master mode the first bit sent is `ninth_bit_i`, followed by `tx_data_i[7:0]` MSB first. In slave mode, 2'b11 behaves as 8-bit.
- R3: In master mode, `sclk_o` changes level every H module clocks while a word is in flight. `div_sel_i` gives H = 4, 2, 1 and 7 for 2'b00, 2'b01, 2'b10 and 2'b11, so the serial clock runs at the module clock divided by 8, 4, 2 or 14.
- R4: While no master word is in flight, `sclk_o` equals `cpol_i`.
- R5: With `cpha_i`=0, data is captured on the leading (first) edge of each bit and data-out changes on the trailing edge. With `cpha_i`=1, data-out changes on the leading edge and data is captured on the trailing edge. Bits travel MSB first in both directions.
- R6: `sdo_o` equals `do_level_i` when the block is idle, and at all times while `force_do_i`=1.
- R7: `din_sync_o` equals the value `din_i` had two module clock cycles earlier.
- R8: In slave mode with `ssn_gate_i`=1, a high `ssn_i` prevents any word from starting and aborts a word in progress. With `ssn_gate_i`=0, `ssn_i` is ignored.
- R9: When `on_i` drops in master mode, the word in flight and any word in the holding stage are still sent. After that the block is idle and `tx_ready_o` stays low.
- R10: `rx_valid_o` is high for exactly one cycle per completed word, and `rx_data_o` is valid in that cycle.
- R11: `tx_ready_o` is high exactly when `on_i`=1 and the holding stage is empty. A word is accepted on a cycle with `tx_valid_i` and `tx_ready_o` both high. The slave starts a word only when the holding stage is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_i | input | 1 | Block enable |
| slave_i | input | 1 | 1 selects slave mode, 0 selects master mode |
| word_sel_i | input | 2 | Word length select |
| div_sel_i | input | 2 | Master serial clock divider select |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Serial clock phase |
| force_do_i | input | 1 | Force data-out to `do_level_i` |
| do_level_i | input | 1 | Idle or forced data-out level |
| ninth_bit_i | input | 1 | First bit of a 9-bit master word |
| ssn_gate_i | input | 1 | 1 makes `ssn_i` gate slave transfers |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_data_i | input | 32 | Transmit word |
| tx_ready_o | output | 1 | Holding stage can accept a word |
| rx_valid_o | output | 1 | Word-complete strobe |
| rx_data_o | output | 32 | Received word, right-justified |
| busy_o | output | 1 | A word is in flight |
| sclk_o | output | 1 | Master serial clock |
| sclk_i | input | 1 | External serial clock (slave) |
| ssn_i | input | 1 | Slave select, active low |
| sdo_o | output | 1 | Serial data out |
| din_i | input | 1 | Serial data in |
| din_sync_o | output | 1 | Synchronized data-in level |

## Verification
`din_sync_o` trails `din_i` by two clock edges. `tx_ready_o` falls on the edge after acceptance and rises on the edge that moves the word into the shifter. `rx_valid_o` rises on the same edge that returns `sclk_o` to its idle level. Master timing is measured cycle by cycle: the bench samples every output on the falling clock edge, counts `sclk_o` transitions, and measures the spacing between the first two transitions. In slave tests the bench drives its own serial clock with eight-cycle half periods, which leaves ample margin for the three-edge synchronizer and edge-detect latency before each sample of `sdo_o`.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned BITS_W = $clog2(DW) + 1;
  localparam int unsigned EDGE_W = BITS_W + 1;
  localparam int unsigned HALF_W = 3;
  localparam int unsigned SYNC_W = 3;

  typedef enum logic [1:0] {
    WS_8  = 2'b00,
    WS_16 = 2'b01,
    WS_32 = 2'b10,
    WS_9  = 2'b11
  } word_sel_e;

  function automatic logic [BITS_W-1:0] word_bits(input word_sel_e sel, input logic slave);
    case (sel)
      WS_8:    return BITS_W'(8);
      WS_16:   return BITS_W'(16);
      WS_32:   return BITS_W'(32);
      default: return slave ? BITS_W'(8) : BITS_W'(9);
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] div);
    case (div)
      2'b00:   return HALF_W'(4);
      2'b01:   return HALF_W'(2);
      2'b10:   return HALF_W'(1);
      default: return HALF_W'(7);
    endcase
  endfunction

  // word left-justified so the shifter always emits bit DW-1
  function automatic logic [DW-1:0] load_vec(input word_sel_e sel, input logic slave,
                                             input logic ninth, input logic [DW-1:0] d);
    case (sel)
      WS_8:    return {d[7:0], 24'b0};
      WS_16:   return {d[15:0], 16'b0};
      WS_32:   return d;
      default: return slave ? {d[7:0], 24'b0} : {ninth, d[7:0], 23'b0};
    endcase
  endfunction
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned HW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_div_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < half_i));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_core_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [DW-1:0]     load_i,
  input  logic [BITS_W-1:0] nbits_i,
  input  logic              cpha_i,
  input  logic              edge_i,
  input  logic              cap_bit_i,
  output logic              run_o,
  output logic              phase_o,
  output logic              sdo_bit_o,
  output logic              done_o,
  output logic [DW-1:0]     rx_word_o
);
  logic              run_q, done_q;
  logic [EDGE_W-1:0] edge_q;
  logic [BITS_W-1:0] nbits_q;
  logic [DW-1:0]     tx_q, rx_q, rx_out_q;
  logic [EDGE_W-1:0] last_edge;
  logic              lead, capture, shift, last;
  logic [DW-1:0]     rx_next;

  assign last_edge = {nbits_q, 1'b0} - 1'b1;
  assign lead      = !edge_q[0];
  assign capture   = lead ^ cpha_i;
  assign shift     = !capture && (edge_q != '0);
  assign last      = (edge_q == last_edge);
  assign rx_next   = {rx_q[DW-2:0], cap_bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      edge_q   <= '0;
      nbits_q  <= BITS_W'(8);
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (clr_i) begin
        run_q  <= 1'b0;
        edge_q <= '0;
      end else if (!run_q) begin
        if (start_i) begin
          run_q   <= 1'b1;
          edge_q  <= '0;
          nbits_q <= nbits_i;
          tx_q    <= load_i;
          rx_q    <= '0;
        end
      end else if (edge_i) begin
        if (capture) rx_q <= rx_next;
        if (shift)   tx_q <= {tx_q[DW-2:0], 1'b0};
        if (last) begin
          run_q    <= 1'b0;
          done_q   <= 1'b1;
          edge_q   <= '0;
          rx_out_q <= capture ? rx_next : rx_q;
        end else begin
          edge_q <= edge_q + 1'b1;
        end
      end
    end
  end

  assign run_o     = run_q;
  assign phase_o   = edge_q[0];
  assign sdo_bit_o = tx_q[DW-1];
  assign done_o    = done_q;
  assign rx_word_o = rx_out_q;

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_edge_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (edge_q <= last_edge));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_core_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          on_i,
  input  logic          slave_i,
  input  logic [1:0]    word_sel_i,
  input  logic [1:0]    div_sel_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          force_do_i,
  input  logic          do_level_i,
  input  logic          ninth_bit_i,
  input  logic          ssn_gate_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  output logic          busy_o,
  output logic          sclk_o,
  input  logic          sclk_i,
  input  logic          ssn_i,
  output logic          sdo_o,
  input  logic          din_i,
  output logic          din_sync_o
);
  logic              ssn_s, sclk_s, din_s, sclk_q;
  logic              hold_full_q;
  logic [DW-1:0]     hold_q;
  logic              slave_sel, clr, start, accept;
  logic              run, phase, sdo_bit, tick, edge_stb, cap_bit;
  word_sel_e         wsel;

  assign wsel = word_sel_e'(word_sel_i);

  spi_sync2 #(.W(SYNC_W), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ssn_i, sclk_i, din_i}),
    .q_o    ({ssn_s, sclk_s, din_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end

  assign slave_sel  = !ssn_gate_i || !ssn_s;
  assign clr        = slave_i && (!on_i || !slave_sel);
  assign tx_ready_o = on_i && !hold_full_q;
  assign accept     = tx_valid_i && tx_ready_o;
  assign start      = hold_full_q && !run && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (slave_i && !on_i) begin
      hold_full_q <= 1'b0;
    end else if (start) begin
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_full_q <= 1'b1;
      hold_q      <= tx_data_i;
    end
  end

  spi_clk_div #(.HW(HALF_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run && !slave_i),
    .half_i (half_cycles(div_sel_i)),
    .tick_o (tick)
  );

  // master samples raw data-in: it owns the clock, sync delay would miss /2
  assign edge_stb = slave_i ? (sclk_s ^ sclk_q) : tick;
  assign cap_bit  = slave_i ? din_s : din_i;

  spi_shift_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .start_i   (start),
    .load_i    (load_vec(wsel, slave_i, ninth_bit_i, hold_q)),
    .nbits_i   (word_bits(wsel, slave_i)),
    .cpha_i    (cpha_i),
    .edge_i    (edge_stb),
    .cap_bit_i (cap_bit),
    .run_o     (run),
    .phase_o   (phase),
    .sdo_bit_o (sdo_bit),
    .done_o    (rx_valid_o),
    .rx_word_o (rx_data_o)
  );

  assign busy_o     = run;
  assign sclk_o     = cpol_i ^ (!slave_i && run && phase);
  assign sdo_o      = (force_do_i || !run) ? do_level_i : sdo_bit;
  assign din_sync_o = din_s;

  assert_hold_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
  assert_sclk_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !slave_i) |-> (sclk_o == cpol_i));
  assert_force_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_do_i |-> (sdo_o == do_level_i));
  assert_done_has_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(busy_o));
endmodule

// File: tb/tb_spi_shift_core.sv
module tb_spi_shift_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic on = 0, slave = 0, cpol = 0, cpha = 0, force_do = 0, do_level = 0, ninth = 0, ssn_gate = 0;
  logic [1:0] wsel = 0, dsel = 0;
  logic tx_valid = 0;
  logic [31:0] tx_data = 0;
  logic tx_ready, rx_valid, busy, sclk_o, sdo, din_sync;
  logic [31:0] rx_data;
  logic sclk_in = 0, ssn = 1, din_drv = 0, loop_en = 0;
  wire din = loop_en ? sdo : din_drv;

  int n_chk = 0, n_bad = 0;
  int rxv_cnt = 0;
  logic [31:0] rx_last = 0, rx_prev = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_core dut (
    .clk_i(clk), .rst_ni(rst_n), .on_i(on), .slave_i(slave), .word_sel_i(wsel), .div_sel_i(dsel),
    .cpol_i(cpol), .cpha_i(cpha), .force_do_i(force_do), .do_level_i(do_level), .ninth_bit_i(ninth),
    .ssn_gate_i(ssn_gate), .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .busy_o(busy), .sclk_o(sclk_o), .sclk_i(sclk_in),
    .ssn_i(ssn), .sdo_o(sdo), .din_i(din), .din_sync_o(din_sync)
  );

  always @(negedge clk) if (rx_valid) begin
    rxv_cnt++;
    rx_prev = rx_last;
    rx_last = rx_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int nbits(input logic [1:0] ws, input logic slv);
    case (ws)
      2'b00: return 8;
      2'b01: return 16;
      2'b10: return 32;
      default: return slv ? 8 : 9;
    endcase
  endfunction

  function automatic int half(input logic [1:0] d);
    case (d) 2'b00: return 4; 2'b01: return 2; 2'b10: return 1; default: return 7; endcase
  endfunction

  function automatic logic [31:0] mask(input int n);
    return (n == 32) ? 32'hffff_ffff : ((32'd1 << n) - 1);
  endfunction

  function automatic logic [31:0] exp_loop(input logic [1:0] ws, input logic [31:0] d,
                                           input logic nb, input logic frc, input logic lvl);
    int n = nbits(ws, 1'b0);
    if (frc) return lvl ? mask(n) : 32'd0;
    if (ws == 2'b11) return {23'd0, nb, d[7:0]};
    return d & mask(n);
  endfunction

  task automatic write_word(input logic [31:0] d);
    int w = 0;
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    while (!tx_ready && w < 5000) begin @(negedge clk); w++; end
    step(1);
    tx_valid = 0;
  endtask

  // master loopback: data-out wired to data-in
  task automatic do_master(input logic [1:0] ws, input logic [1:0] dv, input logic pl, input logic ph,
                           input logic [31:0] d, input logic nb);
    int tog = 0, t1 = 0, gap = -1, cyc = 0, n;
    bit got = 0;
    logic prev;
    logic [31:0] rxd = 0;
    wsel = ws; dsel = dv; cpol = pl; cpha = ph; ninth = nb;
    n = nbits(ws, 1'b0);
    step(1);
    write_word(d);
    prev = sclk_o;
    while (!got && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (sclk_o !== prev) begin
        tog++;
        if (tog == 1) t1 = cyc; else if (tog == 2) gap = cyc - t1;
        prev = sclk_o;
      end
      if (rx_valid) begin got = 1; rxd = rx_data; end
    end
    check("R1/R2/R5 loopback word", rxd, exp_loop(ws, d, nb, force_do, do_level));
    check("R1 clock transitions", tog, 2*n);
    check("R3 half period", gap, half(dv));
    @(negedge clk);
    check("R10 single-cycle strobe", rx_valid, 0);
    check("R4 idle clock level", sclk_o, pl);
    check("R6 idle data-out", sdo, do_level);
  endtask

  // bench acts as master towards the slave
  task automatic do_slave(input logic [1:0] ws, input logic pl, input logic ph, input logic [31:0] md,
                          input logic [31:0] sd, input logic wr);
    int n = nbits(ws, 1'b1);
    int base, w = 0;
    logic [31:0] cap = 0;
    wsel = ws; cpol = pl; cpha = ph;
    sclk_in = pl;
    step(6);
    base = rxv_cnt;
    if (wr) write_word(sd);
    if (ssn_gate) ssn = 0;
    step(8);
    for (int b = n-1; b >= 0; b--) begin
      if (!ph) begin
        din_drv = md[b]; step(8);
        @(negedge clk); cap = {cap[30:0], sdo}; step(1);
        sclk_in = !pl; step(8); sclk_in = pl;
      end else begin
        sclk_in = !pl; din_drv = md[b]; step(8);
        @(negedge clk); cap = {cap[30:0], sdo}; step(1);
        sclk_in = pl; step(8);
      end
    end
    while (rxv_cnt == base && w < 40) begin step(1); w++; end
    check("R8/R5 slave received word", rx_last, md & mask(n));
    check("R5/R2 slave sent word", cap, sd & mask(n));
    check("R10 one strobe per slave word", rxv_cnt - base, 1);
    ssn = 1;
    step(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed = 7;
    logic h0 = 0, h1 = 0, h2 = 0;
    void'($urandom(seed));
    on = 1; do_level = 1;
    step(3);
    // reset state
    check("R11 ready at reset", tx_ready, 1);
    check("R10 no strobe at reset", rx_valid, 0);
    check("R4 clock idle at reset", sclk_o, 0);
    check("R6 data-out idle at reset", sdo, 1);
    check("R11 not busy at reset", busy, 0);
    rst_n = 1;
    step(2);

    // R7 synchronizer delay
    for (int i = 0; i < 24; i++) begin
      din_drv = $urandom % 2;
      h2 = h1; h1 = h0; h0 = din_drv;
      @(negedge clk);
      if (i >= 2) check("R7 data-in sync delay", din_sync, h2);
      step(1);
    end

    // master loopback, directed corners then random
    loop_en = 1;
    do_master(2'b00, 2'b10, 0, 0, 32'h0000_00A5, 0);
    do_master(2'b11, 2'b11, 1, 1, 32'h0000_003C, 1);
    do_master(2'b11, 2'b00, 0, 1, 32'h0000_00FF, 0);
    do_master(2'b10, 2'b10, 1, 0, 32'h8000_0001, 0);
    do_master(2'b01, 2'b01, 0, 0, 32'hDEAD_BEEF, 0);
    for (int i = 0; i < 20; i++) begin
      logic [1:0] ws, dv;
      ws = 2'($urandom); dv = 2'($urandom);
      do_level = 1'($urandom);
      do_master(ws, dv, 1'($urandom), 1'($urandom), $urandom, 1'($urandom));
    end

    // R6 forced level overrides shifted data
    force_do = 1; do_level = 1;
    do_master(2'b00, 2'b10, 0, 0, 32'h0000_0000, 0);
    do_level = 0;
    do_master(2'b01, 2'b01, 1, 1, 32'h0000_FFFF, 0);
    force_do = 0; do_level = 1;

    // R9 drain on turn-off
    begin
      int base, w = 0;
      wsel = 2'b01; dsel = 2'b10; cpol = 0; cpha = 0;
      step(1);
      base = rxv_cnt;
      write_word(32'h0000_1234);
      write_word(32'h0000_ABCD);
      on = 0;
      while (rxv_cnt < base + 2 && w < 1000) begin step(1); w++; end
      step(2);
      check("R9 words sent after off", rxv_cnt - base, 2);
      check("R9 first drained word", rx_prev, 32'h0000_1234);
      check("R9 second drained word", rx_last, 32'h0000_ABCD);
      @(negedge clk);
      check("R9 ready low while off", tx_ready, 0);
      check("R9 idle after drain", busy, 0);
      step(1);
      on = 1;
      step(2);
    end

    // slave mode
    loop_en = 0; slave = 1; ssn_gate = 1; ssn = 1;
    step(4);
    do_slave(2'b00, 0, 0, 32'h0000_0096, 32'h0000_005A, 1);
    do_slave(2'b01, 1, 1, 32'h0000_C3A1, 32'h0000_7E18, 1);
    do_slave(2'b11, 0, 1, 32'h0000_01E7, 32'h0000_0133, 1);
    for (int i = 0; i < 3; i++)
      do_slave(2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom, 1);

    // R8 gated: deselected slave ignores clocks and keeps the held word
    begin
      int base;
      cpol = 0; cpha = 0; wsel = 2'b00; sclk_in = 0;
      step(4);
      base = rxv_cnt;
      write_word(32'h0000_00C9);
      for (int i = 0; i < 16; i++) begin sclk_in = ~sclk_in; step(6); end
      @(negedge clk);
      check("R8 deselected not busy", busy, 0);
      check("R8 held word kept", tx_ready, 0);
      check("R8 no strobe while deselected", rxv_cnt - base, 0);
      step(1);
      // R8 select ignored: transfer runs with ssn high
      ssn_gate = 0; ssn = 1;
      do_slave(2'b00, 0, 0, 32'h0000_0042, 32'h0000_00C9, 0);
    end

    finish_run();
  end
endmodule